// File: doc/BRIEF.md
# Nonvolatile Image Store/Recall Sequencer

This block copies a whole SRAM image to and from its nonvolatile shadow array, one word per clock. When power comes up it restores the shadow contents into the SRAM. Normal access is held off until that restore is complete. Afterwards it accepts save (STORE) and restore (RECALL) requests from the serial command front end. It also accepts a falling edge on an active-low hardware save pin. When the power-good indication drops, it saves the image automatically, running from the hold-up capacitor until the last word is copied.

A dirty flag records whether the SRAM has been written since the last completed transfer. Any save request that finds the image clean is dropped. While a transfer runs, `busy` stays high and the block pulls the shared save pin low. The array copy itself belongs to the surrounding logic, which moves one word for each `xfer_en` cycle at `xfer_addr`, in the direction given by `xfer_dir`. Parameters set the transfer length, the settling count, the synchronizer depth, and whether the automatic and pin save triggers exist at all.

Top module: `nv_image_sequencer`

## Requirements
- R1: After reset, `ready` and `busy` are low. Once the synchronized `pwr_good` is high, a RECALL runs (`xfer_dir` = 0). `ready` stays low until that RECALL has finished and only then goes high.
- R2: A transfer that is not aborted asserts `xfer_en` for exactly WORDS consecutive cycles, with `xfer_addr` counting up from 0 to WORDS-1. It then holds `busy` high for SETTLE_CYC more cycles with `xfer_en` low, so the busy period is WORDS+SETTLE_CYC cycles.
- R3: A `sw_store_req` pulse while idle, after at least one `sram_wr` pulse taken while idle, starts a STORE (`xfer_dir` = 1).
- R4: A STORE request from any trigger is dropped when no `sram_wr` has been taken since the last completed transfer. No `xfer_en` or `busy` follows.
- R5: A `sw_recall_req` pulse while idle starts a RECALL whether or not the image is dirty. Its completion clears the dirty flag.
- R6: With AUTO_STORE_EN=1, a drop of `pwr_good` while idle and dirty starts a STORE. That STORE runs all WORDS words even though power stays low. After it, `ready` stays low and no transfer occurs until `pwr_good` returns, which starts a RECALL.
- R7: With AUTO_STORE_EN=0, a drop of `pwr_good` starts no transfer and takes `ready` low, even if the image is dirty. `sw_store_req` still saves.
- R8: With PIN_STORE_EN=1, a falling edge on `store_pin_n` while idle and dirty starts a STORE. With PIN_STORE_EN=0 the pin has no effect.
- R9: `store_pin_drive` is high exactly in the cycles where `busy` is high.
- R10: Requests and `sram_wr` pulses that arrive while `busy` is high are ignored. In particular, a write during a STORE does not mark the image dirty again.
- R11: A drop of `pwr_good` during a RECALL aborts it before its last word. If the image is dirty and AUTO_STORE_EN=1, a full STORE starts immediately from address 0. Otherwise the block goes unpowered with `ready` low.
- R12: When several triggers coincide while idle, the priority is power loss, then the pin, then `sw_store_req`, then `sw_recall_req`. Only the winner runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-good indication, asynchronous, synchronized inside |
| store_pin_n | input | 1 | Level of the shared active-low hardware save pin |
| sw_store_req | input | 1 | One-cycle software save request |
| sw_recall_req | input | 1 | One-cycle software restore request |
| sram_wr | input | 1 | One-cycle pulse for each host write to the SRAM |
| busy | output | 1 | A transfer or its settling phase is in progress |
| ready | output | 1 | Idle and powered, so normal SRAM access is allowed |
| store_pin_drive | output | 1 | Pull the shared save pin low |
| xfer_en | output | 1 | Copy one word this cycle |
| xfer_dir | output | 1 | 1 = SRAM to shadow (STORE), 0 = shadow to SRAM (RECALL) |
| xfer_addr | output | $clog2(WORDS) | Word address of the current copy |

## Verification
The main instance is built with WORDS=8, SETTLE_CYC=3 and both automatic and pin saves enabled. With those values each busy period lasts 11 cycles, so the bench can count every word and every settle cycle of every transfer. It can also drop power partway through a RECALL. A second instance is built with AUTO_STORE_EN=0 and PIN_STORE_EN=0. It shares the power signal with the first, which brings the disabled-trigger behaviour within reach alongside the enabled one.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_COPY,
        ST_SETTLE
    } seq_state_e;

    localparam logic DIR_RECALL = 1'b0;
    localparam logic DIR_STORE  = 1'b1;

endpackage

// File: rtl/nvseq_sync.sv
module nvseq_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/nvseq_arb.sv
module nvseq_arb #(
    parameter bit AUTO_STORE_EN = 1'b1
) (
    input  logic pwr_ok,
    input  logic pin_fall,
    input  logic sw_store,
    input  logic sw_recall,
    input  logic dirty,
    output logic start,
    output logic start_dir,
    output logic power_off
);
    import nvseq_pkg::*;

    always_comb begin
        start     = 1'b0;
        start_dir = DIR_STORE;
        power_off = 1'b0;
        if (!pwr_ok) begin
            start     = AUTO_STORE_EN && dirty;
            power_off = !(AUTO_STORE_EN && dirty);
        end else if (pin_fall) begin
            start = dirty;
        end else if (sw_store) begin
            start = dirty;
        end else if (sw_recall) begin
            start     = 1'b1;
            start_dir = DIR_RECALL;
        end
    end

endmodule

// File: rtl/nv_image_sequencer.sv
module nv_image_sequencer
    import nvseq_pkg::*;
#(
    parameter int WORDS         = 64,
    parameter int SETTLE_CYC    = 16,
    parameter int SYNC_STAGES   = 2,
    parameter bit AUTO_STORE_EN = 1'b1,
    parameter bit PIN_STORE_EN  = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pwr_good,
    input  logic                     store_pin_n,
    input  logic                     sw_store_req,
    input  logic                     sw_recall_req,
    input  logic                     sram_wr,
    output logic                     busy,
    output logic                     ready,
    output logic                     store_pin_drive,
    output logic                     xfer_en,
    output logic                     xfer_dir,
    output logic [$clog2(WORDS)-1:0] xfer_addr
);

    localparam int AW = $clog2(WORDS);
    localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [AW-1:0] LAST_ADDR  = AW'(WORDS - 1);
    localparam logic [SW-1:0] SETTLE_TOP = SW'(SETTLE_CYC - 1);

    typedef struct packed {
        seq_state_e    state;
        logic          dir;
        logic [AW-1:0] addr;
        logic [SW-1:0] settle;
        logic          dirty;
        logic          pin_prev;
    } seq_t;

    seq_t q, d;

    logic pwr_ok, pin_s, pin_fall;
    logic arb_start, arb_dir, arb_off;
    logic dirty_w;

    nvseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pwr_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pwr_good),
        .dout (pwr_ok)
    );

    nvseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (store_pin_n),
        .dout (pin_s)
    );

    assign pin_fall = PIN_STORE_EN && q.pin_prev && !pin_s;

    nvseq_arb #(.AUTO_STORE_EN(AUTO_STORE_EN)) u_arb (
        .pwr_ok   (pwr_ok),
        .pin_fall (pin_fall),
        .sw_store (sw_store_req),
        .sw_recall(sw_recall_req),
        .dirty    (q.dirty),
        .start    (arb_start),
        .start_dir(arb_dir),
        .power_off(arb_off)
    );

    always_comb begin
        d          = q;
        d.pin_prev = pin_s;
        unique case (q.state)
            ST_OFF: begin
                d.dirty = 1'b0;
                if (pwr_ok) begin
                    d.state = ST_COPY;
                    d.dir   = DIR_RECALL;
                    d.addr  = '0;
                end
            end
            ST_IDLE: begin
                if (sram_wr) d.dirty = 1'b1;
                if (arb_off) begin
                    d.state = ST_OFF;
                end else if (arb_start) begin
                    d.state = ST_COPY;
                    d.dir   = arb_dir;
                    d.addr  = '0;
                end
            end
            ST_COPY, ST_SETTLE: begin
                if (q.dir == DIR_RECALL && !pwr_ok) begin
                    if (AUTO_STORE_EN && q.dirty) begin
                        d.state = ST_COPY;
                        d.dir   = DIR_STORE;
                        d.addr  = '0;
                    end else begin
                        d.state = ST_OFF;
                    end
                end else if (q.state == ST_COPY) begin
                    if (q.addr == LAST_ADDR) begin
                        d.state  = ST_SETTLE;
                        d.settle = SETTLE_TOP;
                    end else begin
                        d.addr = q.addr + 1'b1;
                    end
                end else if (q.settle == '0) begin
                    d.dirty = 1'b0;
                    d.state = (q.dir == DIR_STORE && !pwr_ok) ? ST_OFF : ST_IDLE;
                end else begin
                    d.settle = q.settle - 1'b1;
                end
            end
            default: d.state = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_OFF;
            q.pin_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy            = (q.state == ST_COPY) || (q.state == ST_SETTLE);
    assign ready           = (q.state == ST_IDLE);
    assign store_pin_drive = busy;
    assign xfer_en         = (q.state == ST_COPY);
    assign xfer_dir        = q.dir;
    assign xfer_addr       = q.addr;
    assign dirty_w         = q.dirty;

endmodule

// File: rtl/nvseq_checker.sv
module nvseq_checker #(
    parameter int WORDS = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     busy,
    input logic                     ready,
    input logic                     xfer_en,
    input logic                     xfer_dir,
    input logic [$clog2(WORDS)-1:0] xfer_addr,
    input logic                     dirty
);

    localparam int AW = $clog2(WORDS);

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && $past(xfer_en) && xfer_addr != '0) |-> xfer_addr == $past(xfer_addr) + 1'b1);

    // R2
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !xfer_en) |=> (!xfer_en || xfer_addr == '0));

    // R6
    store_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && xfer_dir && xfer_addr != AW'(WORDS - 1)) |=> (xfer_en && xfer_dir));

    // R1
    ready_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(busy));

    // R4
    store_needs_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(xfer_en) && xfer_dir && $past(ready)) |-> $past(dirty));

endmodule

bind nv_image_sequencer nvseq_checker #(.WORDS(WORDS)) u_nvseq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .ready    (ready),
    .xfer_en  (xfer_en),
    .xfer_dir (xfer_dir),
    .xfer_addr(xfer_addr),
    .dirty    (dirty_w)
);

// File: tb/nv_image_sequencer_test.sv
module nv_image_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int SC = 3;
    localparam int AW = $clog2(W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b1;
    logic ext_pin = 1'b0, ext_pin_b = 1'b0;
    logic sw_store = 1'b0, sw_recall = 1'b0, wr = 1'b0;
    logic sw_store_b = 1'b0, wr_b = 1'b0;

    logic busy, ready, drive, xen, xdir;
    logic [AW-1:0] xaddr;
    logic b_busy, b_ready, b_drive, b_xen, b_xdir;
    logic [AW-1:0] b_xaddr;
    logic pin_n, pin_n_b;

    assign pin_n   = ~(ext_pin | drive);
    assign pin_n_b = ~(ext_pin_b | b_drive);

    always #(CLK_PERIOD/2) clk = ~clk;

    nv_image_sequencer #(.WORDS(W), .SETTLE_CYC(SC), .SYNC_STAGES(2),
        .AUTO_STORE_EN(1'b1), .PIN_STORE_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .store_pin_n(pin_n),
        .sw_store_req(sw_store), .sw_recall_req(sw_recall), .sram_wr(wr),
        .busy(busy), .ready(ready), .store_pin_drive(drive),
        .xfer_en(xen), .xfer_dir(xdir), .xfer_addr(xaddr));

    nv_image_sequencer #(.WORDS(W), .SETTLE_CYC(SC), .SYNC_STAGES(2),
        .AUTO_STORE_EN(1'b0), .PIN_STORE_EN(1'b0)) uut_bare (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .store_pin_n(pin_n_b),
        .sw_store_req(sw_store_b), .sw_recall_req(1'b0), .sram_wr(wr_b),
        .busy(b_busy), .ready(b_ready), .store_pin_drive(b_drive),
        .xfer_en(b_xen), .xfer_dir(b_xdir), .xfer_addr(b_xaddr));

    int checks = 0, fails = 0;
    int st_runs = 0, rc_runs = 0, cur_len = 0, last_len = 0, prev_len = 0;
    int last_dir = 0, busy_cnt = 0, last_busy = 0, busy_periods = 0;
    int addr_err = 0, drive_err = 0, exp_next = 0, b_st = 0, b_xfer = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (drive !== busy) drive_err++;
            if (xen) begin
                if (xaddr == '0) begin
                    if (cur_len > 0) prev_len = cur_len;
                    cur_len = 1;
                    if (xdir) st_runs++; else rc_runs++;
                    last_dir = int'(xdir);
                end else begin
                    if (int'(xaddr) != exp_next) addr_err++;
                    cur_len++;
                end
                exp_next = int'(xaddr) + 1;
                last_len = cur_len;
            end
            if (busy) busy_cnt++;
            else if (busy_cnt > 0) begin
                last_busy = busy_cnt;
                busy_periods++;
                busy_cnt = 0;
            end
            if (b_xen) begin
                b_xfer++;
                if (b_xdir && b_xaddr == '0) b_st++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        int q = 0;
        while (q < 8) begin
            @(negedge clk);
            q = (busy || b_busy) ? 0 : q + 1;
        end
    endtask

    task automatic pulse_wr();
        @(negedge clk) wr = 1'b1; wr_b = 1'b1;
        @(negedge clk) wr = 1'b0; wr_b = 1'b0;
    endtask

    task automatic pulse_store();
        @(negedge clk) sw_store = 1'b1;
        @(negedge clk) sw_store = 1'b0;
    endtask

    task automatic pulse_recall();
        @(negedge clk) sw_recall = 1'b1;
        @(negedge clk) sw_recall = 1'b0;
    endtask

    task automatic t_powerup();
        repeat (3) @(negedge clk);
        check(ready == 1'b0 && busy == 1'b0, "R1 reset state", int'(ready), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(busy == 1'b1 && ready == 1'b0, "R1 ready held during power-up recall", int'(ready), 0);
        quiet();
        check(rc_runs == 1 && last_dir == 0, "R1 power-up recall", rc_runs, 1);
        check(last_len == W, "R2 recall word count", last_len, W);
        check(last_busy == W + SC, "R2 busy length", last_busy, W + SC);
        check(ready == 1'b1, "R1 ready after recall", int'(ready), 1);
    endtask

    task automatic t_sw_store();
        int s0 = st_runs;
        pulse_wr();
        pulse_store();
        quiet();
        check(st_runs == s0 + 1 && last_dir == 1, "R3 software store", st_runs - s0, 1);
        check(last_len == W && last_busy == W + SC, "R2 store length", last_busy, W + SC);
    endtask

    task automatic t_store_clean();
        int s0 = st_runs, b0 = busy_periods;
        pulse_store();
        quiet();
        check(st_runs == s0 && busy_periods == b0, "R4 clean store dropped", busy_periods - b0, 0);
    endtask

    task automatic t_busy_ignore();
        int s0 = st_runs, r0 = rc_runs;
        pulse_wr();
        pulse_store();
        repeat (2) @(negedge clk);
        @(negedge clk) wr = 1'b1; sw_recall = 1'b1;
        @(negedge clk) wr = 1'b0; sw_recall = 1'b0;
        quiet();
        pulse_store();
        quiet();
        check(st_runs == s0 + 1, "R10 write during busy ignored", st_runs - s0, 1);
        check(rc_runs == r0, "R10 recall during busy ignored", rc_runs - r0, 0);
    endtask

    task automatic t_sw_recall();
        int s0 = st_runs, r0 = rc_runs;
        pulse_wr();
        pulse_recall();
        quiet();
        check(rc_runs == r0 + 1 && last_len == W, "R5 software recall", rc_runs - r0, 1);
        pulse_store();
        quiet();
        check(st_runs == s0, "R5 recall clears dirty", st_runs - s0, 0);
    endtask

    task automatic t_priority();
        int s0 = st_runs, r0 = rc_runs;
        pulse_wr();
        @(negedge clk) sw_store = 1'b1; sw_recall = 1'b1;
        @(negedge clk) sw_store = 1'b0; sw_recall = 1'b0;
        quiet();
        check(st_runs == s0 + 1 && rc_runs == r0, "R12 store beats recall", rc_runs - r0, 0);
    endtask

    task automatic t_pin();
        int s0 = st_runs, bx = b_xfer;
        pulse_wr();
        @(negedge clk) ext_pin = 1'b1; ext_pin_b = 1'b1;
        repeat (3) @(negedge clk);
        ext_pin = 1'b0; ext_pin_b = 1'b0;
        quiet();
        check(st_runs == s0 + 1 && last_len == W, "R8 pin store", st_runs - s0, 1);
        check(b_xfer == bx, "R8 pin ignored when disabled", b_xfer - bx, 0);
        check(drive_err == 0, "R9 drive follows busy", drive_err, 0);
        s0 = st_runs;
        @(negedge clk) ext_pin = 1'b1;
        repeat (3) @(negedge clk);
        ext_pin = 1'b0;
        quiet();
        check(st_runs == s0, "R4 clean pin store dropped", st_runs - s0, 0);
    endtask

    task automatic t_pwrfail();
        int s0 = st_runs, r0 = rc_runs, bx = b_xfer;
        pulse_wr();
        @(negedge clk) pwr_good = 1'b0;
        quiet();
        check(st_runs == s0 + 1 && last_len == W, "R6 auto store", last_len, W);
        check(ready == 1'b0, "R6 ready low after auto store", int'(ready), 0);
        check(b_xfer == bx && b_ready == 1'b0, "R7 no auto store when disabled", b_xfer - bx, 0);
        repeat (20) @(negedge clk);
        check(st_runs == s0 + 1 && rc_runs == r0, "R6 quiet while unpowered", rc_runs - r0, 0);
        @(negedge clk) pwr_good = 1'b1;
        quiet();
        check(rc_runs == r0 + 1 && ready == 1'b1, "R6 recall on return", rc_runs - r0, 1);
        check(b_ready == 1'b1, "R7 bare recovers", int'(b_ready), 1);
    endtask

    task automatic t_abort();
        int s0 = st_runs, r0 = rc_runs;
        pulse_wr();
        pulse_recall();
        repeat (2) @(negedge clk);
        pwr_good = 1'b0;
        quiet();
        check(rc_runs == r0 + 1 && prev_len < W, "R11 recall aborted", prev_len, W - 1);
        check(st_runs == s0 + 1 && last_len == W && last_dir == 1, "R11 store after abort", last_len, W);
        @(negedge clk) pwr_good = 1'b1;
        quiet();
        r0 = rc_runs; s0 = st_runs;
        pulse_recall();
        repeat (2) @(negedge clk);
        pwr_good = 1'b0;
        quiet();
        check(st_runs == s0 && last_len < W && ready == 1'b0, "R11 clean abort goes off", st_runs - s0, 0);
        @(negedge clk) pwr_good = 1'b1;
        quiet();
        check(ready == 1'b1, "R11 recovers", int'(ready), 1);
    endtask

    task automatic t_bare_sw();
        int bs = b_st;
        pulse_wr();
        @(negedge clk) sw_store_b = 1'b1;
        @(negedge clk) sw_store_b = 1'b0;
        quiet();
        check(b_st == bs + 1, "R7 software store still works", b_st - bs, 1);
        check(addr_err == 0, "R2 address sequence", addr_err, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_powerup();
        t_sw_store();
        t_store_clean();
        t_busy_ignore();
        t_sw_recall();
        t_priority();
        t_pin();
        t_pwrfail();
        t_abort();
        t_bare_sw();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule